// File: doc/BRIEF.md
# Eight-Bit Tri-State Arithmetic Logic Unit

This block is a purely combinational eight-bit arithmetic logic unit for a small processor datapath. It takes two operands, an incoming carry flag, a four-bit operation code, an operand-flip request and an output enable. It produces an eight-bit result on a shared bus and four status flags: carry, zero, sign and signed overflow. The bus is released (high impedance) whenever the output enable is low, so other sources can share the same wires.

Internally the operand pair first passes through one swap-and-mask multiplexer. The multiplexer can exchange the operands, force either one to zero, or force the second one to the constant one. All the operation units see its outputs. One ripple-carry adder that can be turned into a subtractor covers every arithmetic opcode, and also copy, negate and exclusive-or. It does so by decoding the opcode into swap, zero, one, subtract and carry-use controls. Shifts, bitwise logic and carry replication each have a small unit of their own. Each unit drives the bus only when its opcode is selected.

Top module: `alu8_core`

## Requirements
- R1: The 4-bit `op_sel` encodes MOV=0, ADD=1, ADC=2, SUB=3, SBB=4, INC=5, DEC=6, NEG=7, NOT=8, SHL=9, SHR=10, SAR=11, AND=12, OR=13, XOR=14, EXP=15. Operands are A=`opnd_a` and B=`opnd_b`, after any flip.
- R2: When `out_en` is 0, `bus_active` is 0 and `res_bus` is not driven. When `out_en` is 1, `bus_active` is 1 and `res_bus` carries the result. The flags always reflect the selected operation.
- R3: With `flip`=1, A and B are exchanged before every operation unit, for all sixteen opcodes.
- R4: ADD gives A+B, ADC gives A+B+carry_in and INC gives A+1, each modulo 256. `flag_c` is the carry out of bit 7.
- R5: SUB gives A−B, SBB gives A−B−carry_in, DEC gives A−1 and NEG gives 0−A, each modulo 256. `flag_c` is 1 exactly when a borrow occurs, meaning the true difference is negative.
- R6: For the eight arithmetic opcodes (ADD through NEG), `flag_v` is 1 exactly when the two's-complement result falls outside −128..127.
- R7: MOV returns B unchanged and clears `flag_c` and `flag_v`.
- R8: SHL moves A left one place with 0 entering bit 0, and `flag_c` takes old bit 7. SHR moves A right one place with 0 entering bit 7, and `flag_c` takes old bit 0. SAR moves A right one place keeping bit 7, and `flag_c` takes old bit 0. `flag_v` is 0 for all three shifts.
- R9: NOT gives ~A, and AND, OR and XOR give the bitwise results of A and B. All four clear `flag_c` and `flag_v`.
- R10: EXP sets all eight result bits to `carry_in` and clears `flag_c` and `flag_v`.
- R11: For every opcode, `flag_z` is 1 exactly when the result byte is zero, and `flag_s` equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry flag |
| op_sel | input | 4 | Operation code |
| flip | input | 1 | Exchange the operands before use |
| out_en | input | 1 | Drive the result bus when 1 |
| res_bus | output | 8 | Shared result bus, high impedance when released |
| bus_active | output | 1 | 1 while the block drives the result bus |
| flag_c | output | 1 | Carry, borrow or shifted-out bit |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result bit 7 |
| flag_v | output | 1 | Signed overflow |

## Verification
The operand flip and the carry-in–dependent arithmetic can act in the same evaluation. When they do, the exchange changes which operand is subtracted and so changes the borrow, the overflow and the zero flag together. Vectors are provoked with `flip` set on SUB, SBB and NEG, using boundary operands 0x00, 0x01, 0x7F, 0x80 and 0xFF with both carry values, and then with a long pseudo-random run where the flip, carry and enable are random. Every evaluation is judged against a behavioural integer model that applies the flip first and derives each flag from the true mathematical result.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the eight-bit ALU: opcode encoding and unit count.
// Assumes a four-bit opcode space that is fully used by sixteen operations.
package alu8_pkg;
    localparam int OP_BITS = 4;
    localparam int N_OPS   = 1 << OP_BITS;

    typedef enum logic [OP_BITS-1:0] {
        OP_MOV = 4'd0,  OP_ADD = 4'd1,  OP_ADC = 4'd2,  OP_SUB = 4'd3,
        OP_SBB = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_NEG = 4'd7,
        OP_NOT = 4'd8,  OP_SHL = 4'd9,  OP_SHR = 4'd10, OP_SAR = 4'd11,
        OP_AND = 4'd12, OP_OR  = 4'd13, OP_XOR = 4'd14, OP_EXP = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu8_opnd_mux.sv
`timescale 1ns/1ps
// Operand swap-and-mask multiplexer.
// Exchanges the operands when swap is set, then can force either output to
// zero and can force bit 0 of the second output to one.
// Assumes purely combinational use; no storage.
module alu8_opnd_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         swap,
    input  logic         zero_x,
    input  logic         zero_y,
    input  logic         one_y,
    output logic [W-1:0] out_x,
    output logic [W-1:0] out_y
);
    // Select, mask and constant-insert the two operands.
    always_comb begin
        out_x = swap ? in_b : in_a;
        out_y = swap ? in_a : in_b;
        if (zero_x) out_x = '0;
        if (zero_y) out_y = '0;
        out_y[0] = out_y[0] | one_y;
    end
endmodule

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// Ripple-carry adder that a control line turns into a subtractor.
// Each cell inverts its first operand into the carry logic when sub is set,
// so the carry chain carries borrows. Also exposes the bitwise exclusive-or.
// Assumes cin is a carry for addition and a borrow for subtraction.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf,
    output logic [W-1:0] xr
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic prop;
        logic xs;
        // One bit: sum is shared by add and subtract, carry logic uses controlled inversion.
        assign prop         = x[i] ^ y[i];
        assign xs           = x[i] ^ sub;
        assign sum[i]       = prop ^ chain[i];
        assign xr[i]        = prop;
        assign chain[i+1]   = (xs & y[i]) | (chain[i] & (xs ^ y[i]));
    end

    assign cout = chain[W];
    // Signed overflow from operand and result sign bits.
    assign ovf  = sub ? ((x[W-1] != y[W-1]) && (sum[W-1] != x[W-1]))
                      : ((x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]));

    logic [W:0] chk_add;
    logic [W:0] chk_sub;
    assign chk_add = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign chk_sub = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};

    // Compare the ripple chain against plain arithmetic.
    always_comb begin
        if (!$isunknown({x, y, sub, cin})) begin
            if (!sub) begin
                a_r4_add_sum: assert ({cout, sum} == chk_add)
                    else $error("R4 ripple sum/carry mismatch");
            end else begin
                a_r5_sub_borrow: assert ({cout, sum} == chk_sub)
                    else $error("R5 ripple difference/borrow mismatch");
            end
        end
    end
endmodule

// File: rtl/alu8_bitunit.sv
`timescale 1ns/1ps
// Shift, bitwise-logic and carry-replication units.
// Every shift moves by exactly one place and reports the bit that leaves.
// Assumes operands have already passed the swap multiplexer.
module alu8_bitunit #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] not_r,
    output logic [W-1:0] and_r,
    output logic [W-1:0] or_r,
    output logic [W-1:0] shl_r,
    output logic [W-1:0] shr_r,
    output logic [W-1:0] sar_r,
    output logic [W-1:0] exp_r,
    output logic         top_out,
    output logic         low_out
);
    // Bitwise logic.
    assign not_r = ~x;
    assign and_r = x & y;
    assign or_r  = x | y;
    // Single-place shifts; the arithmetic right shift repeats the sign bit.
    assign shl_r = {x[W-2:0], 1'b0};
    assign shr_r = {1'b0, x[W-1:1]};
    assign sar_r = {x[W-1], x[W-1:1]};
    assign top_out = x[W-1];
    assign low_out = x[0];
    // Carry replicated across the word.
    assign exp_r = {W{cin}};
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
// Eight-bit combinational ALU with a shared tri-state result bus.
// Decodes the opcode into operand-mux and adder controls, runs all units in
// parallel, and lets only the selected unit drive the bus. The bus floats
// when out_en is low. Flags follow the selected operation regardless of out_en.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]       opnd_a,
    input  logic [W-1:0]       opnd_b,
    input  logic               carry_in,
    input  logic [OP_BITS-1:0] op_sel,
    input  logic               flip,
    input  logic               out_en,
    output logic [W-1:0]       res_bus,
    output logic               bus_active,
    output logic               flag_c,
    output logic               flag_z,
    output logic               flag_s,
    output logic               flag_v
);
    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    logic sw_i, zx, zy, one, sub, use_c, arith;
    // Map each opcode onto operand-mux and adder controls.
    always_comb begin
        {sw_i, zx, zy, one, sub, use_c, arith} = '0;
        case (op)
            OP_MOV: {sw_i, zy}             = 2'b11;
            OP_ADD: arith                  = 1'b1;
            OP_ADC: {use_c, arith}         = 2'b11;
            OP_SUB: {sub, arith}           = 2'b11;
            OP_SBB: {sub, use_c, arith}    = 3'b111;
            OP_INC: {zy, one, arith}       = 3'b111;
            OP_DEC: {zy, one, sub, arith}  = 4'b1111;
            OP_NEG: {sw_i, zx, sub, arith} = 4'b1111;
            default: ;
        endcase
    end

    logic [W-1:0] x, y;
    alu8_opnd_mux #(.W(W)) i_mux (
        .in_a(opnd_a), .in_b(opnd_b), .swap(flip ^ sw_i),
        .zero_x(zx), .zero_y(zy), .one_y(one),
        .out_x(x), .out_y(y)
    );

    logic [W-1:0] sum, xr;
    logic cout, ovf;
    alu8_addsub #(.W(W)) i_addsub (
        .x(x), .y(y), .sub(sub), .cin(use_c & carry_in),
        .sum(sum), .cout(cout), .ovf(ovf), .xr(xr)
    );

    logic [W-1:0] not_r, and_r, or_r, shl_r, shr_r, sar_r, exp_r;
    logic top_out, low_out;
    alu8_bitunit #(.W(W)) i_bits (
        .x(x), .y(y), .cin(carry_in),
        .not_r(not_r), .and_r(and_r), .or_r(or_r),
        .shl_r(shl_r), .shr_r(shr_r), .sar_r(sar_r), .exp_r(exp_r),
        .top_out(top_out), .low_out(low_out)
    );

    logic [W-1:0] unit_val [N_OPS];
    // Wire each unit's output to its opcode slot.
    always_comb begin
        for (int k = 0; k < N_OPS; k++) unit_val[k] = sum;
        unit_val[OP_NOT] = not_r;
        unit_val[OP_SHL] = shl_r;
        unit_val[OP_SHR] = shr_r;
        unit_val[OP_SAR] = sar_r;
        unit_val[OP_AND] = and_r;
        unit_val[OP_OR]  = or_r;
        unit_val[OP_XOR] = xr;
        unit_val[OP_EXP] = exp_r;
    end

    logic [N_OPS-1:0] unit_sel;
    assign unit_sel = out_en ? (N_OPS'(1) << op_sel) : '0;

    logic [W-1:0] gated [N_OPS];
    for (genvar g = 0; g < N_OPS; g++) begin : g_drv
        // Per-unit driver: contributes only when its opcode is enabled.
        assign gated[g] = unit_sel[g] ? unit_val[g] : '0;
    end

    logic [W-1:0] merged;
    // Resolve the shared bus contents from all unit drivers.
    always_comb begin
        merged = '0;
        for (int k = 0; k < N_OPS; k++) merged = merged | gated[k];
    end

    assign bus_active = |unit_sel;
    assign res_bus    = bus_active ? merged : {W{1'bz}};

    logic [W-1:0] op_val;
    assign op_val = unit_val[op_sel];

    // Flags from the selected operation.
    always_comb begin
        flag_c = 1'b0;
        flag_v = 1'b0;
        if (arith) begin
            flag_c = cout;
            flag_v = ovf;
        end else if (op == OP_SHL) begin
            flag_c = top_out;
        end else if (op == OP_SHR || op == OP_SAR) begin
            flag_c = low_out;
        end
    end
    assign flag_z = (op_val == '0);
    assign flag_s = op_val[W-1];

    // Bus, drivers and flag consistency.
    always_comb begin
        if (!$isunknown({op_sel, out_en, carry_in, opnd_a, opnd_b, flip})) begin
            a_r1_single_driver: assert ($onehot0(unit_sel))
                else $error("R1 more than one unit drives the bus");
            if (!out_en) begin
                a_r2_bus_released: assert (!bus_active)
                    else $error("R2 bus driven while disabled");
            end
            if (bus_active && op == OP_EXP) begin
                a_r10_exp_fill: assert (merged == {W{carry_in}})
                    else $error("R10 carry not replicated");
            end
            if (bus_active) begin
                a_r11_zero_flag: assert (flag_z == (merged == '0))
                    else $error("R11 zero flag disagrees with bus");
            end
            if (op == OP_MOV || op >= OP_NOT && op != OP_SHL && op != OP_SHR
                && op != OP_SAR) begin
                a_r9_flags_cleared: assert (!flag_c && !flag_v)
                    else $error("R9 carry/overflow not cleared");
            end
        end
    end
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
// Bench: drives vectors after each rising edge and compares every output
// at the following falling edge against a behavioural integer model.
module test_alu8_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] a, b;
    logic       cin, flip, oe;
    logic [3:0] op;
    logic [7:0] res;
    logic       act, fc, fz, fs, fv;

    alu8_core i_alu8_core (
        .opnd_a(a), .opnd_b(b), .carry_in(cin), .op_sel(op), .flip(flip),
        .out_en(oe), .res_bus(res), .bus_active(act),
        .flag_c(fc), .flag_z(fz), .flag_s(fs), .flag_v(fv)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic string req_of(input int o);
        if (o == 0) return "R7";
        if (o >= 1 && o <= 2) return "R4";
        if (o == 5) return "R4";
        if (o >= 3 && o <= 7) return "R5";
        if (o >= 9 && o <= 11) return "R8";
        if (o == 15) return "R10";
        return "R9";
    endfunction

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Reference model: flip first, then true integer arithmetic.
    function automatic void model(input int ia, input int ib, input int ic,
                                  input int o, input int fl,
                                  output int r, output int c, output int v);
        int ea, eb, t, st;
        ea = fl ? ib : ia;
        eb = fl ? ia : ib;
        c = 0; v = 0; t = 0; st = 0;
        case (o)
            0:  t = eb;
            1:  begin t = ea + eb;      st = sx(ea) + sx(eb);      end
            2:  begin t = ea + eb + ic; st = sx(ea) + sx(eb) + ic; end
            3:  begin t = ea - eb;      st = sx(ea) - sx(eb);      end
            4:  begin t = ea - eb - ic; st = sx(ea) - sx(eb) - ic; end
            5:  begin t = ea + 1;       st = sx(ea) + 1;           end
            6:  begin t = ea - 1;       st = sx(ea) - 1;           end
            7:  begin t = 0 - ea;       st = 0 - sx(ea);           end
            8:  t = 255 - ea;
            9:  begin t = (ea * 2) % 256; c = ea / 128;            end
            10: begin t = ea / 2;       c = ea % 2;                end
            11: begin t = ea / 2 + (ea / 128) * 128; c = ea % 2;   end
            12: t = ea & eb;
            13: t = ea | eb;
            14: t = ea ^ eb;
            default: t = ic ? 255 : 0;
        endcase
        if (o >= 1 && o <= 7) begin
            c = (t > 255 || t < 0) ? 1 : 0;
            v = (st > 127 || st < -128) ? 1 : 0;
        end
        r = ((t % 256) + 256) % 256;
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h c=%0d op=%0d flip=%0d oe=%0d)",
                     tag, actual, expected, a, b, cin, op, flip, oe);
        end
    endtask

    task automatic apply(input int ia, input int ib, input int ic, input int o,
                         input int fl, input int en, input string pre);
        int r, c, v;
        string tag;
        @(posedge clk);
        #1;
        a = 8'(ia); b = 8'(ib); cin = 1'(ic); op = 4'(o); flip = 1'(fl); oe = 1'(en);
        model(ia, ib, ic, o, fl, r, c, v);
        tag = fl ? {pre, req_of(o), "+R3"} : {pre, req_of(o)};
        @(negedge clk);
        check({"R2 ", tag}, int'(act), en);
        if (en != 0) check(tag, int'(res), r);
        check({tag, " carry"}, int'(fc), c);
        check({(o >= 1 && o <= 7) ? "R6 " : "", tag, " ovf"}, int'(fv), v);
        check({"R11 ", tag, " zero"}, int'(fz), (r == 0) ? 1 : 0);
        check({"R11 ", tag, " sign"}, int'(fs), r / 128);
    endtask

    initial begin
        int pats[5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        logic [15:0] lfsr = 16'hACE1;
        a = '0; b = '0; cin = 1'b0; op = '0; flip = 1'b0; oe = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R2: idle state after bench reset: bus released.
        apply(8'h5A, 8'h3C, 0, 1, 0, 0, "");
        // Directed boundary cases.
        apply(8'hFF, 8'h00, 1, 2, 0, 1, "");   // R4 ADC wraps to zero with carry
        apply(8'h7F, 8'h00, 0, 5, 0, 1, "");   // R4/R6 INC into overflow
        apply(8'h00, 8'h01, 0, 3, 0, 1, "");   // R5 SUB borrow
        apply(8'h01, 8'h00, 0, 3, 1, 1, "");   // R3 flipped SUB borrow
        apply(8'h80, 8'h00, 0, 7, 0, 1, "");   // R5/R6 NEG of most negative
        apply(8'h00, 8'h00, 0, 6, 0, 1, "");   // R5 DEC of zero
        apply(8'h10, 8'h10, 1, 4, 1, 1, "");   // R5 SBB with flip and borrow in
        apply(8'h12, 8'h34, 1, 0, 0, 1, "");   // R7 MOV ignores carry
        apply(8'h12, 8'h34, 0, 0, 1, 1, "");   // R3/R7 MOV flipped
        apply(8'h80, 8'h00, 0, 9, 0, 1, "");   // R8 SHL out of top
        apply(8'h01, 8'h00, 0, 10, 0, 1, "");  // R8 SHR out of bottom
        apply(8'h81, 8'h00, 0, 11, 0, 1, "");  // R8 SAR keeps sign
        apply(8'hF0, 8'h3C, 1, 14, 0, 1, "");  // R9 XOR
        apply(8'h00, 8'h00, 1, 15, 0, 1, "");  // R10 EXP of one
        apply(8'hFF, 8'hFF, 0, 15, 0, 1, "");  // R10 EXP of zero
        apply(8'hAA, 8'h55, 1, 15, 0, 0, "");  // R2 flags while released
        // R1: every opcode over boundary operand pairs, both carries, both flips.
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int k = 0; k < 4; k++)
                        apply(pats[i], pats[j], k % 2, o, k / 2, 1, "R1 ");
        // Pseudo-random run including enable toggling.
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(int'(lfsr[7:0]), int'(lfsr[15:8] ^ lfsr[7:0]), int'(lfsr[3]),
                  int'(lfsr[11:8]), int'(lfsr[5]), (lfsr[14:12] != 3'b000) ? 1 : 0, "");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule